// File: doc/BRIEF.md
# DAC Sample FIFO with Swing Mode

This block is the sample store in front of a digital-to-analog converter. A host writes data words into it, and it holds one word at a time on the converter's data output. It has three operating modes. In bypass mode a single register passes every write straight to the output. In normal mode the words queue up and each trigger moves the output on to the next stored word. In swing mode the read pointer bounces between the full point and the one-entry-left point, so a stored waveform plays forward and then backward with no host writes.

A trigger-source select input chooses between a hardware strobe and a software strobe. The block reports five status signals: full, nearly empty, below-watermark, and one-cycle overflow and underflow pulses. The read and write pointers are outputs for status readback. A FIFO clear input returns both pointers to a common address, which empties the store. The depth is a power of two from 2 to 256 entries and is reported as a 3-bit code.

Top module: `dac_sample_fifo`

## Requirements
- R1: After reset, dacOut, rdPtr and wrPtr are 0, and full, nearlyEmpty, overflow and underflow are all 0.
- R2: With opMode 0 (bypass), or the reserved value 3 which behaves the same, a write puts wrData on dacOut after the next clock edge. Triggers are ignored, and neither pointer moves.
- R3: With opMode 1 (normal) and the store not full, a write stores wrData at wrPtr and increments wrPtr modulo the depth. A write into an empty store also puts the word on dacOut.
- R4: In normal mode, a selected trigger while two or more entries remain increments rdPtr, and dacOut becomes the next word in write order.
- R5: full is 1 exactly when the number of held entries equals the depth. nearlyEmpty is 1 exactly when one entry remains.
- R6: In normal or swing mode, a write while full is dropped, leaves wrPtr unchanged, and raises overflow for exactly one cycle after the edge.
- R7: In normal mode, a selected trigger while one or no entry remains leaves rdPtr and dacOut unchanged and raises underflow for one cycle. In swing mode this applies only when the store is empty.
- R8: watermark is 1 exactly when the number of held entries is less than wmLevel. wmLevel ranges from 0 to the depth.
- R9: With opMode 2 (swing), triggers increment rdPtr until one entry remains, then decrement it until the store is full again, then increment again. The turnaround raises no underflow. dacOut always shows the entry rdPtr points to.
- R10: trigSel 0 selects hwTrig and trigSel 1 selects swTrig. The unselected strobe has no effect.
- R11: fifoClr sets both pointers to 0, empties the store and cancels any write or trigger in that cycle. dacOut keeps its value.
- R12: depthCode equals DEPTH_LOG2-1, so code n means 2^(n+1) entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opMode | input | 2 | 0 bypass, 1 normal, 2 swing, 3 same as bypass |
| trigSel | input | 1 | 0 selects hwTrig, 1 selects swTrig |
| hwTrig | input | 1 | Hardware trigger strobe, one cycle per trigger |
| swTrig | input | 1 | Software trigger strobe, one cycle per trigger |
| wrEn | input | 1 | Data write strobe |
| wrData | input | DATA_W | Data word to store |
| fifoClr | input | 1 | Empty the store and reset both pointers |
| wmLevel | input | DEPTH_LOG2+1 | Watermark level, 0 to depth |
| dacOut | output | DATA_W | Word presented to the converter |
| rdPtr | output | DEPTH_LOG2 | Current read pointer |
| wrPtr | output | DEPTH_LOG2 | Current write pointer |
| full | output | 1 | Store holds depth entries |
| nearlyEmpty | output | 1 | Exactly one entry remains |
| watermark | output | 1 | Entry count below wmLevel |
| overflow | output | 1 | One-cycle pulse: write dropped while full |
| underflow | output | 1 | One-cycle pulse: trigger refused |
| depthCode | output | 3 | Depth code, DEPTH_LOG2-1 |

## Verification
A wrong entry count shows up on full, nearlyEmpty or watermark at the negedge right after the edge that caused it. It also shows up a few triggers later as a refused trigger or a missed swing turnaround. A wrong read pointer, or a wrong word read from the store, shows on dacOut after the same edge. A scoreboard compares every expected output word, so any such error is caught on the next trigger. A wrong swing direction is caught at the first turnaround, because the expected sequence reverses there and the observed one would not.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_SWING  = 2'd2,
    MODE_RSVD   = 2'd3
  } opMode_e;

  // strobes from control to datapath for one clock
  typedef struct packed {
    logic store;    // write wrData into the entry at wAddr
    logic takeIn;   // load dacOut from wrData
    logic takeMem;  // load dacOut from the entry at rAddr
  } dpStrobe_t;

endpackage

// File: rtl/dsf_ctrl.sv
module dsf_ctrl
  import dsf_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    opMode,
  input  logic          trigSel,
  input  logic          hwTrig,
  input  logic          swTrig,
  input  logic          wrEn,
  input  logic          fifoClr,
  input  logic [PW:0]   wmLevel,
  output dpStrobe_t     strobe,
  output logic [PW-1:0] wAddr,
  output logic [PW-1:0] rAddr,
  output logic [PW-1:0] rdPtr,
  output logic [PW-1:0] wrPtr,
  output logic          full,
  output logic          nearlyEmpty,
  output logic          watermark,
  output logic          overflow,
  output logic          underflow
);

  localparam int          DEPTH   = 1 << PW;
  localparam logic [PW:0] FULLCNT = (PW+1)'(DEPTH);
  localparam logic [PW:0] ONECNT  = (PW+1)'(1);

  opMode_e       modeE;
  logic [PW:0]   cnt, cntNxt;
  logic [PW-1:0] rdP, wrP;
  logic          dirUp, dirNext;
  logic          isFifo, isSwing, trig;
  logic          isFull, isOne, isEmpty;
  logic          moveUp, moveDn, wrOk, ovfNow, udfNow;

  assign modeE = opMode_e'(opMode);

  always_comb begin
    isFifo  = (modeE == MODE_NORMAL) || (modeE == MODE_SWING);
    isSwing = (modeE == MODE_SWING);
    trig    = isFifo && (trigSel ? swTrig : hwTrig);
    isFull  = (cnt == FULLCNT);
    isOne   = (cnt == ONECNT);
    isEmpty = (cnt == '0);

    // swing direction for this trigger: turn at the two boundaries
    dirNext = 1'b1;
    if (isSwing) begin
      if (dirUp && isOne)        dirNext = 1'b0;
      else if (!dirUp && isFull) dirNext = 1'b1;
      else                       dirNext = dirUp;
    end

    moveUp = 1'b0;
    moveDn = 1'b0;
    udfNow = 1'b0;
    if (trig && !fifoClr) begin
      if (isSwing) begin
        if (isEmpty)      udfNow = 1'b1;
        else if (dirNext) moveUp = 1'b1;
        else              moveDn = 1'b1;
      end else begin
        if (cnt < (PW+1)'(2)) udfNow = 1'b1;
        else                  moveUp = 1'b1;
      end
    end

    // a write needs a free entry after this cycle's pointer move
    wrOk   = isFifo && wrEn && !fifoClr && !isFull &&
             !(moveDn && (cnt == FULLCNT - ONECNT));
    ovfNow = isFifo && wrEn && !fifoClr && !wrOk;

    cntNxt = cnt + (PW+1)'(wrOk) - (PW+1)'(moveUp) + (PW+1)'(moveDn);

    rAddr = moveDn ? (rdP - 1'b1) : (rdP + 1'b1);
    wAddr = wrP;

    strobe.store   = wrOk;
    strobe.takeIn  = !fifoClr && wrEn && (!isFifo || (wrOk && isEmpty));
    strobe.takeMem = moveUp || moveDn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      rdP       <= '0;
      wrP       <= '0;
      dirUp     <= 1'b1;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (fifoClr) begin
      cnt       <= '0;
      rdP       <= '0;
      wrP       <= '0;
      dirUp     <= 1'b1;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      cnt       <= cntNxt;
      overflow  <= ovfNow;
      underflow <= udfNow;
      if (wrOk)   wrP <= wrP + 1'b1;
      if (moveUp) rdP <= rdP + 1'b1;
      if (moveDn) rdP <= rdP - 1'b1;
      if (!isSwing)               dirUp <= 1'b1;
      else if (moveUp || moveDn)  dirUp <= moveUp;
    end
  end

  assign rdPtr       = rdP;
  assign wrPtr       = wrP;
  assign full        = isFull;
  assign nearlyEmpty = isOne;
  assign watermark   = (cnt < wmLevel);

endmodule

// File: rtl/dsf_data.sv
module dsf_data
  import dsf_pkg::*;
#(
  parameter int DW = 12,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [PW-1:0] wAddr,
  input  logic [PW-1:0] rAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] dacOut
);

  localparam int DEPTH = 1 << PW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (strobe.store && (wAddr == PW'(e))) mem[e] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dacOut <= '0;
    else if (strobe.takeIn)  dacOut <= wrData;
    else if (strobe.takeMem) dacOut <= mem[rAddr];
  end

endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo
  import dsf_pkg::*;
#(
  parameter int DEPTH_LOG2 = 3,
  parameter int DATA_W     = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            opMode,
  input  logic                  trigSel,
  input  logic                  hwTrig,
  input  logic                  swTrig,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  fifoClr,
  input  logic [DEPTH_LOG2:0]   wmLevel,
  output logic [DATA_W-1:0]     dacOut,
  output logic [DEPTH_LOG2-1:0] rdPtr,
  output logic [DEPTH_LOG2-1:0] wrPtr,
  output logic                  full,
  output logic                  nearlyEmpty,
  output logic                  watermark,
  output logic                  overflow,
  output logic                  underflow,
  output logic [2:0]            depthCode
);

  localparam int PW = DEPTH_LOG2;

  dpStrobe_t     strobe;
  logic [PW-1:0] wAddr, rAddr;

  dsf_ctrl #(.PW(PW)) u_ctrl (
    .clk, .rstN, .opMode, .trigSel, .hwTrig, .swTrig, .wrEn, .fifoClr,
    .wmLevel, .strobe, .wAddr, .rAddr, .rdPtr, .wrPtr, .full,
    .nearlyEmpty, .watermark, .overflow, .underflow
  );

  dsf_data #(.DW(DATA_W), .PW(PW)) u_data (
    .clk, .rstN, .strobe, .wAddr, .rAddr, .wrData, .dacOut
  );

  // R12: depth code n stands for 2^(n+1) entries
  assign depthCode = 3'(DEPTH_LOG2 - 1);

endmodule

// File: rtl/dac_sample_fifo_chk.sv
module dac_sample_fifo_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic [1:0]    opMode,
  input logic          trigSel,
  input logic          hwTrig,
  input logic          swTrig,
  input logic          wrEn,
  input logic          fifoClr,
  input logic [PW-1:0] rdPtr,
  input logic [PW-1:0] wrPtr,
  input logic          full,
  input logic          nearlyEmpty,
  input logic          overflow,
  input logic          underflow
);

  logic isFifo, selTrig;
  assign isFifo  = (opMode == 2'd1) || (opMode == 2'd2);
  assign selTrig = trigSel ? swTrig : hwTrig;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (isFifo && wrEn && full && !fifoClr) |=> (overflow && $stable(wrPtr))); // R6

  AST_BYPASS_PTRS: assert property (@(posedge clk) disable iff (!rstN)
    (!isFifo && !fifoClr) |=> ($stable(rdPtr) && $stable(wrPtr))); // R2

  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> $stable(rdPtr)); // R7

  AST_NORMAL_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 2'd1 && selTrig && nearlyEmpty && !fifoClr) |=> underflow); // R7

  AST_SWING_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 2'd2 && selTrig && nearlyEmpty && !fifoClr) |=>
      (!underflow && rdPtr == PW'($past(rdPtr) - 1'b1))); // R9

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> (rdPtr == wrPtr && !full && !nearlyEmpty)); // R11

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(overflow && underflow)); // R7

endmodule

bind dac_sample_fifo dac_sample_fifo_chk #(.PW(DEPTH_LOG2)) u_chk (
  .clk(clk), .rstN(rstN), .opMode(opMode), .trigSel(trigSel),
  .hwTrig(hwTrig), .swTrig(swTrig), .wrEn(wrEn), .fifoClr(fifoClr),
  .rdPtr(rdPtr), .wrPtr(wrPtr), .full(full), .nearlyEmpty(nearlyEmpty),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/dac_sample_fifo_tb.sv
module dac_sample_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LG = 3;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    opMode = 2'd0;
  logic          trigSel = 1'b0, hwTrig = 1'b0, swTrig = 1'b0;
  logic          wrEn = 1'b0, fifoClr = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [LG:0]   wmLevel = '0;
  logic [DW-1:0] dacOut;
  logic [LG-1:0] rdPtr, wrPtr;
  logic          full, nearlyEmpty, watermark, overflow, underflow;
  logic [2:0]    depthCode;

  dac_sample_fifo #(.DEPTH_LOG2(LG), .DATA_W(DW)) u_dut (
    .clk, .rstN, .opMode, .trigSel, .hwTrig, .swTrig, .wrEn, .wrData,
    .fifoClr, .wmLevel, .dacOut, .rdPtr, .wrPtr, .full, .nearlyEmpty,
    .watermark, .overflow, .underflow, .depthCode
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    tests = 0;
  int    fails = 0;
  longint cyc = 0;
  bit    done = 1'b0;

  typedef struct { int val; longint due; string req; } exp_t;
  exp_t expQ[$];

  always @(posedge clk) cyc++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare dacOut against the scoreboard when an item is due
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].due == cyc) begin
      exp_t it;
      it = expQ.pop_front();
      chk(it.req, int'(dacOut), it.val);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectOut(input int v, input string req);
    exp_t it;
    it.val = v; it.due = cyc + 1; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic wr(input int d);
    wrEn = 1'b1; wrData = DW'(d);
    tick();
    wrEn = 1'b0;
  endtask

  task automatic trig(input bit useHw);
    if (useHw) hwTrig = 1'b1; else swTrig = 1'b1;
    tick();
    hwTrig = 1'b0; swTrig = 1'b0;
  endtask

  task automatic clr();
    fifoClr = 1'b1;
    tick();
    fifoClr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 dacOut", int'(dacOut), 0);
    chk("R1 rdPtr", int'(rdPtr), 0);
    chk("R1 wrPtr", int'(wrPtr), 0);
    chk("R1 flags", int'({full, nearlyEmpty, overflow, underflow}), 0);
    chk("R12 depthCode", int'(depthCode), LG - 1);

    // R2 bypass
    opMode = 2'd0;
    expectOut('h123, "R2 bypass write"); wr('h123);
    chk("R2 wrPtr", int'(wrPtr), 0);
    trigSel = 1'b1;
    expectOut('h123, "R2 trigger ignored"); trig(1'b0);
    chk("R2 rdPtr", int'(rdPtr), 0);
    opMode = 2'd3;
    expectOut('h0AB, "R2 reserved mode"); wr('h0AB);

    clr();
    chk("R11 dacOut kept", int'(dacOut), 'h0AB);

    // R3/R5/R8 normal fill
    opMode = 2'd1; wmLevel = 4'd3;
    expectOut('h100, "R3 first write shown"); wr('h100);
    chk("R3 wrPtr", int'(wrPtr), 1);
    chk("R5 nearlyEmpty", int'(nearlyEmpty), 1);
    chk("R8 watermark low", int'(watermark), 1);
    for (int i = 1; i < 8; i++) wr('h100 + i);
    chk("R3 wrPtr wrap", int'(wrPtr), 0);
    chk("R5 full", int'(full), 1);
    chk("R5 nearlyEmpty off", int'(nearlyEmpty), 0);
    chk("R8 watermark high", int'(watermark), 0);

    // R6 overflow
    wr('h1FF);
    chk("R6 overflow", int'(overflow), 1);
    chk("R6 wrPtr held", int'(wrPtr), 0);
    chk("R6 still full", int'(full), 1);
    tick();
    chk("R6 pulse ends", int'(overflow), 0);

    // R10 hw strobe ignored while sw selected
    expectOut('h100, "R10 unselected hw"); trig(1'b1);
    chk("R10 rdPtr held", int'(rdPtr), 0);

    // R4 stepping
    for (int i = 1; i < 8; i++) begin
      expectOut('h100 + i, "R4 next word"); trig(1'b0);
      chk("R4 rdPtr", int'(rdPtr), i);
      if (i == 6) chk("R8 watermark at 2", int'(watermark), 1);
    end
    chk("R5 nearlyEmpty at 1", int'(nearlyEmpty), 1);

    // R7 underflow at nearly empty
    expectOut('h107, "R7 output held"); trig(1'b0);
    chk("R7 underflow", int'(underflow), 1);
    chk("R7 rdPtr held", int'(rdPtr), 7);
    tick();
    chk("R7 pulse ends", int'(underflow), 0);

    // R10 hw selected
    trigSel = 1'b0;
    wr('h200);
    expectOut('h200, "R10 hw trigger"); trig(1'b1);
    chk("R10 rdPtr", int'(rdPtr), 0);
    expectOut('h200, "R10 unselected sw"); trig(1'b0);
    chk("R10 sw ignored", int'(underflow), 0);

    // R11 clear
    clr();
    chk("R11 rdPtr", int'(rdPtr), 0);
    chk("R11 wrPtr", int'(wrPtr), 0);
    chk("R11 empty flags", int'({full, nearlyEmpty}), 0);
    chk("R11 dacOut kept", int'(dacOut), 'h200);
    trigSel = 1'b1;
    trig(1'b0);
    chk("R7 empty trigger", int'(underflow), 1);

    // R9 swing
    opMode = 2'd2; wmLevel = '0;
    expectOut('h300, "R9 fill first"); wr('h300);
    for (int i = 1; i < 8; i++) wr('h300 + i);
    chk("R9 full", int'(full), 1);
    for (int i = 1; i < 8; i++) begin
      expectOut('h300 + i, "R9 upward"); trig(1'b0);
    end
    chk("R9 rdPtr top", int'(rdPtr), 7);
    chk("R9 nearlyEmpty", int'(nearlyEmpty), 1);
    for (int i = 6; i >= 0; i--) begin
      expectOut('h300 + i, "R9 downward"); trig(1'b0);
      chk("R9 no underflow", int'(underflow), 0);
    end
    chk("R9 rdPtr bottom", int'(rdPtr), 0);
    chk("R9 full again", int'(full), 1);
    expectOut('h301, "R9 upward again"); trig(1'b0);
    chk("R9 rdPtr", int'(rdPtr), 1);

    tick();
    chk("scoreboard drained", expQ.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule